// File: doc/BRIEF.md
# Configuration Bitstream Width Reducer

This block sits between a wide DMA-fed stream and a narrow device configuration port. It receives a partial configuration image as 256-bit AXI4-Stream beats and hands it to the port as a series of 32-bit writes, one word per clock, each marked by a write-enable. A small beat buffer decouples the two sides. The stream can then run in bursts while the port sees an unbroken series of writes for as long as data is buffered. At 100 MHz and 32 bits, the port side limits the transfer to 400 MB/s.

A reconfiguration sequencer controls the block with two signals. It pulses a start strobe to arm the block for one image. The block then accepts beats until the beat flagged as last, closes its input again, and pulses a done strobe once the final valid word of that beat has reached the port. On the final beat, the byte-keep qualifier selects which 32-bit lanes carry configuration words. Lanes it marks as empty are skipped without spending a cycle.

Top module: `cfgn_width_reducer`

## Requirements
- R1: After reset, s_tready, cfg_we_o and done_o are all low.
- R2: Until start_i is pulsed, s_tready stays low, so a waiting stream beat is held off and no configuration write occurs.
- R3: In the cycle after the beat carrying s_tlast is accepted, s_tready drops and stays low until the next start_i pulse.
- R4: The block buffers at most 8 beats. s_tready is low while 8 beats are held, and no accepted beat is lost.
- R5: A beat that is not the final one produces exactly eight writes. Its lanes go out in ascending order: bits 31:0 first, then 63:32, and so on, up to bits 255:224.
- R6: On the final beat, lane k (bits 32k+31:32k) is written if at least one of s_tkeep[4k+3:4k] is set, and is skipped otherwise. Lane 0 is always written. Surviving lanes keep ascending order.
- R7: One word is written per cycle with cfg_we_o high. No idle cycle appears between writes while a beat is buffered or being split.
- R8: done_o is high for exactly one cycle: the cycle right after the write of the last valid word of the final beat.
- R9: Word order across beats follows stream order, also when s_tvalid has gaps between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sequencer strobe arming the block for one image |
| s_tdata | input | 256 | Stream beat data |
| s_tkeep | input | 32 | Byte qualifier, used on the final beat only |
| s_tlast | input | 1 | Marks the final beat of the image |
| s_tvalid | input | 1 | Beat present |
| s_tready | output | 1 | Block accepts the beat |
| cfg_data_o | output | 32 | Configuration word |
| cfg_we_o | output | 1 | Write-enable for cfg_data_o |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench offers data before the start strobe and after a final beat. A block that ignored arming would take those beats and write them to the port. A long continuous burst fills the buffer. A wrong full flag would show up there as either lost or duplicated words, or as a gap in the write sequence. Final beats with sparse, empty, and single-byte keep patterns cover lane skipping. A wrong lane test would write a stale lane or drop a valid one, and a skip that costs a cycle would break contiguity. The bench also measures the done strobe against the cycle of the last write, so a strobe that is early, late or stretched is caught.

// File: rtl/cfgn_pkg.sv
package cfgn_pkg;
  localparam int unsigned DEF_IN_W    = 256;
  localparam int unsigned DEF_OUT_W   = 32;
  localparam int unsigned DEF_DEPTH   = 8;
endpackage

// File: rtl/cfgn_beat_fifo.sv
module cfgn_beat_fifo #(
  parameter int unsigned ENTRY_W = 265,
  parameter int unsigned DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               pop,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               empty,
  output logic               full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (fill == '0);
  assign full     = (fill == CNT_W'(DEPTH));
  assign rd_entry = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop); // R9
endmodule

// File: rtl/cfgn_lane_serializer.sv
module cfgn_lane_serializer #(
  parameter int unsigned IN_W  = 256,
  parameter int unsigned OUT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          head_avail,
  input  logic [IN_W-1:0]               head_data,
  input  logic [IN_W/OUT_W-1:0]         head_lanes,
  input  logic                          head_last,
  output logic                          head_take,
  output logic [OUT_W-1:0]              cfg_data_o,
  output logic                          cfg_we_o,
  output logic                          done_o
);
  localparam int unsigned LANES = IN_W / OUT_W;

  logic [IN_W-1:0]  cur_data;
  logic [LANES-1:0] cur_lanes;
  logic             cur_last;
  logic             cur_vld;
  logic             out_last_q;

  // lowest pending lane as a one-hot vector
  function automatic logic [LANES-1:0] low_onehot(input logic [LANES-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  function automatic logic [OUT_W-1:0] lane_word(input logic [IN_W-1:0] d,
                                                 input logic [LANES-1:0] oh);
    logic [OUT_W-1:0] w;
    w = '0;
    for (int k = 0; k < LANES; k++) begin
      if (oh[k]) w = w | d[k*OUT_W +: OUT_W];
    end
    return w;
  endfunction

  logic [LANES-1:0] pick;
  logic [LANES-1:0] remain;
  logic             beat_end;
  logic             word_emit;

  assign pick      = low_onehot(cur_lanes);
  assign remain    = cur_lanes & ~pick;
  assign word_emit = cur_vld;
  assign beat_end  = cur_vld && (remain == '0);
  assign head_take = head_avail && (!cur_vld || beat_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_vld   <= 1'b0;
      cur_lanes <= '0;
      cur_last  <= 1'b0;
      cur_data  <= '0;
    end else if (head_take) begin
      cur_vld   <= 1'b1;
      cur_data  <= head_data;
      cur_lanes <= head_lanes;
      cur_last  <= head_last;
    end else if (beat_end) begin
      cur_vld   <= 1'b0;
    end else if (cur_vld) begin
      cur_lanes <= remain;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_we_o   <= 1'b0;
      cfg_data_o <= '0;
      out_last_q <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      cfg_we_o   <= word_emit;
      cfg_data_o <= word_emit ? lane_word(cur_data, pick) : '0;
      out_last_q <= beat_end && cur_last;
      done_o     <= cfg_we_o && out_last_q;
    end
  end

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) cur_vld |=> cfg_we_o); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_o) |-> $past(cfg_we_o)); // R8
endmodule

// File: rtl/cfgn_width_reducer.sv
module cfgn_width_reducer
  import cfgn_pkg::*;
#(
  parameter int unsigned IN_W  = DEF_IN_W,
  parameter int unsigned OUT_W = DEF_OUT_W,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IN_W-1:0]   s_tdata,
  input  logic [IN_W/8-1:0] s_tkeep,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [OUT_W-1:0]  cfg_data_o,
  output logic              cfg_we_o,
  output logic              done_o
);
  localparam int unsigned LANES   = IN_W / OUT_W;
  localparam int unsigned KEEP_W  = IN_W / 8;
  localparam int unsigned BPL     = OUT_W / 8;
  localparam int unsigned ENTRY_W = IN_W + LANES + 1;

  // lanes to write for a beat: all on inner beats, keep-qualified on the final one
  function automatic logic [LANES-1:0] lanes_of(input logic [KEEP_W-1:0] keep,
                                                input logic last);
    logic [LANES-1:0] m;
    for (int k = 0; k < LANES; k++) begin
      m[k] = last ? (|keep[k*BPL +: BPL]) : 1'b1;
    end
    m[0] = 1'b1;
    return m;
  endfunction

  logic armed_q;
  logic fifo_full, fifo_empty;
  logic beat_acc, last_acc;
  logic head_take;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;

  assign s_tready = armed_q && !fifo_full;
  assign beat_acc = s_tvalid && s_tready;
  assign last_acc = beat_acc && s_tlast;
  assign wr_entry = {s_tlast, lanes_of(s_tkeep, s_tlast), s_tdata};

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (last_acc) armed_q <= 1'b0;
    else if (start_i)  armed_q <= 1'b1;
  end

  cfgn_beat_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (beat_acc),
    .wr_entry (wr_entry),
    .pop      (head_take),
    .rd_entry (rd_entry),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  cfgn_lane_serializer #(.IN_W(IN_W), .OUT_W(OUT_W)) ser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_avail (!fifo_empty),
    .head_data  (rd_entry[IN_W-1:0]),
    .head_lanes (rd_entry[IN_W +: LANES]),
    .head_last  (rd_entry[ENTRY_W-1]),
    .head_take  (head_take),
    .cfg_data_o (cfg_data_o),
    .cfg_we_o   (cfg_we_o),
    .done_o     (done_o)
  );

  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) last_acc |=> !s_tready); // R3
  AST_STAY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (!s_tready && !start_i && !fifo_full) |=> !s_tready); // R2
endmodule

// File: tb/cfgn_width_reducer_tb.sv
module cfgn_width_reducer_tb_top;
  localparam int unsigned IN_W = 256;
  localparam int unsigned OUT_W = 32;
  localparam int unsigned LANES = 8;

  typedef struct packed {
    logic [31:0] beats;
    logic [31:0] keep;
    logic [31:0] seed;
    logic        gaps;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{beats: 32'd1,  keep: 32'hFFFF_FFFF, seed: 32'h1234_0000, gaps: 1'b0},
    '{beats: 32'd3,  keep: 32'h0000_FFFF, seed: 32'hA5A5_0000, gaps: 1'b0},
    '{beats: 32'd12, keep: 32'hF000_000F, seed: 32'h0BAD_0000, gaps: 1'b0},
    '{beats: 32'd2,  keep: 32'h0000_0000, seed: 32'h7777_0000, gaps: 1'b1},
    '{beats: 32'd4,  keep: 32'h0010_0200, seed: 32'hC0DE_0000, gaps: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [IN_W-1:0] s_tdata = '0;
  logic [31:0] s_tkeep = '0;
  logic s_tlast = 1'b0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [OUT_W-1:0] cfg_data_o;
  logic cfg_we_o;
  logic done_o;

  always #2.5 clk = ~clk;

  cfgn_width_reducer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .cfg_data_o(cfg_data_o), .cfg_we_o(cfg_we_o), .done_o(done_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] rx [512];
  int rx_n = 0;
  int first_we = -1;
  int last_we = -1;
  int done_n = 0;
  int done_cyc = -1;
  logic [31:0] exp_w [512];
  int exp_n = 0;
  logic saw_backpressure = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cfg_we_o) begin
      if (rx_n < 512) rx[rx_n] = cfg_data_o;
      rx_n = rx_n + 1;
      if (first_we < 0) first_we = cyc;
      last_we = cyc;
    end
    if (done_o) begin
      done_n = done_n + 1;
      done_cyc = cyc;
    end
    if (s_tvalid && !s_tready && rst_n && first_we >= 0) saw_backpressure = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int b, input int k);
    return seed ^ (32'(b) << 8) ^ (32'(k) * 32'h0101_0011);
  endfunction

  task automatic clear_mon();
    rx_n = 0; first_we = -1; last_we = -1; done_n = 0; done_cyc = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send(input vec_t v);
    int b = 0;
    int slot = 0;
    while (b < int'(v.beats)) begin
      @(negedge clk);
      if (v.gaps && (slot % 3 == 1)) begin
        s_tvalid = 1'b0;
      end else begin
        for (int k = 0; k < LANES; k++) s_tdata[k*32 +: 32] = word_of(v.seed, b, k);
        s_tlast = (b == int'(v.beats) - 1);
        s_tkeep = s_tlast ? v.keep : 32'hFFFF_FFFF;
        s_tvalid = 1'b1;
        if (s_tready) b++;
      end
      slot++;
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic build_exp(input vec_t v);
    exp_n = 0;
    for (int b = 0; b < int'(v.beats); b++) begin
      for (int k = 0; k < LANES; k++) begin
        bit use_lane;
        use_lane = (b < int'(v.beats) - 1) || (k == 0) || (v.keep[4*k +: 4] != 4'h0);
        if (use_lane) begin
          exp_w[exp_n] = word_of(v.seed, b, k);
          exp_n++;
        end
      end
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && done_n == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int mism;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(s_tready == 1'b0, "R1", "tready after reset", s_tready, 0);
    check(cfg_we_o == 1'b0, "R1", "we after reset", cfg_we_o, 0);
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 held off before start
    clear_mon();
    s_tdata = {8{32'hDEAD_BEEF}}; s_tkeep = '1; s_tlast = 1'b1; s_tvalid = 1'b1;
    begin
      int rdy_seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_tready) rdy_seen++; end
      check(rdy_seen == 0, "R2", "tready before start", rdy_seen, 0);
    end
    check(rx_n == 0, "R2", "writes before start", rx_n, 0);
    s_tvalid = 1'b0; s_tlast = 1'b0;

    // table-driven bursts
    for (int i = 0; i < 5; i++) begin
      clear_mon();
      saw_backpressure = 1'b0;
      build_exp(VECS[i]);
      pulse_start();
      send(VECS[i]);
      wait_done();
      check(rx_n == exp_n, (VECS[i].beats == 1) ? "R6" : "R5", "word count", rx_n, exp_n);
      mism = 0;
      for (int j = 0; j < exp_n && j < rx_n; j++) if (rx[j] !== exp_w[j]) mism++;
      check(mism == 0, "R9", "words and order", mism, 0);
      check(done_n == 1, "R8", "done pulses", done_n, 1);
      check(done_cyc == last_we + 1, "R8", "done cycle", done_cyc, last_we + 1);
      if (!VECS[i].gaps)
        check(last_we - first_we == exp_n - 1, "R7", "contiguous writes", last_we - first_we, exp_n - 1);
      if (VECS[i].beats == 12)
        check(saw_backpressure == 1'b1, "R4", "tready dropped when buffer full", saw_backpressure, 1);
    end

    // R6 spot check on final-beat lane selection: keep 32'h0010_0200 -> lanes 0,2,5
    check(exp_n == 3 * 8 + 3, "R6", "final beat lane count", exp_n, 27);

    // R3 closed after final beat until next start
    clear_mon();
    s_tdata = {8{32'h5555_AAAA}}; s_tkeep = '1; s_tlast = 1'b1; s_tvalid = 1'b1;
    begin
      int rdy_seen = 0;
      for (int i = 0; i < 15; i++) begin @(negedge clk); if (s_tready) rdy_seen++; end
      check(rdy_seen == 0, "R3", "tready after final beat", rdy_seen, 0);
    end
    check(rx_n == 0, "R3", "writes after final beat", rx_n, 0);
    s_tvalid = 1'b0; s_tlast = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule